// File: doc/BRIEF.md
# Packet-Filter Arithmetic Execute Unit

This block is the arithmetic stage of a small 64-bit register machine used to run packet-filter programs. It is purely combinational. Each evaluation takes an 8-bit opcode, a 16-bit offset field, a 32-bit immediate and the current values of the destination and source registers. It returns the value to write back to the destination register. Register file access, instruction fetch, memory access and branches all live outside the block.

One opcode covers both the 32-bit and the 64-bit arithmetic classes. The low three bits select the class, bit 3 selects whether the second operand comes from the source register or from the immediate, and the high nibble selects the operation. The offset field chooses signed division, signed modulo and the sign-extending move. Encodings the unit does not support raise an illegal flag and leave the destination value unchanged, so the surrounding pipeline can trap without corrupting state.

The byte-order conversions assume a host byte order set by a parameter, which is little-endian by default.

Top module: `pkt_alu_exec`

## Requirements
- R1: Opcode bits [2:0] select the class: 4 is the 32-bit class and 7 is the 64-bit class. Bit 3 selects the second operand: 1 takes the source register and 0 takes the immediate sign-extended from 32 to 64 bits. Bits [7:4] select the operation: 0 add, 1 sub, 2 mul, 3 div, 4 or, 5 and, 6 left shift, 7 logical right shift, 8 negate, 9 mod, 10 xor, 11 move, 12 arithmetic right shift, 13 byte-order conversion.
- R2: Add, sub, mul, or, and, xor, negate and move wrap modulo the operand width. Every 32-bit-class result other than a byte-order conversion is computed on the low 32 bits of the operands and has bits [63:32] cleared.
- R3: The shift amount is the second operand masked with 0x3F in the 64-bit class and with 0x1F in the 32-bit class. The arithmetic right shift fills with the sign bit of the operand width.
- R4: With offset 0, div and mod are unsigned. In the 64-bit class an immediate divisor is sign-extended to 64 bits first and then treated as unsigned.
- R5: Division by zero yields 0. Modulo by zero yields the destination unchanged in the 64-bit class, and its low 32 bits zero-extended in the 32-bit class.
- R6: With offset 1, div and mod are signed and truncate toward zero, so -13 mod 3 is -1. The most negative value divided by -1 yields the most negative value, and the matching modulo yields 0.
- R7: Move with offset 8, 16 or 32 sign-extends the low byte, halfword or word of the second operand. Offset 32 is legal only in the 64-bit class. In the 32-bit class the result is then zero-extended from 32 bits.
- R8: A byte-order conversion (code 13) in the 32-bit class takes its width from the immediate (16, 32 or 64). Bit 3 selects the target order: 0 is little-endian and 1 is big-endian. On a little-endian host, the little-endian target keeps the low bytes of that width, and the big-endian target reverses their byte order. In both cases the bytes above the width are cleared, and the result is not narrowed to 32 bits.
- R9: A byte-order conversion in the 64-bit class always reverses the low bytes of the selected width and clears the bytes above.
- R10: The illegal flag is raised for any of the following: a class other than 4 or 7; codes 14 and 15; a nonzero offset on an operation that does not use it; a div or mod offset other than 0 or 1; a move offset outside the allowed set; a conversion width other than 16, 32 or 64; and bit 3 set on a 64-bit-class conversion. When the flag is raised, the result equals the destination input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 8 | Opcode: operation, operand select, class |
| off_i | input | 16 | Offset field (signed-division and sign-extend selector) |
| imm_i | input | 32 | Immediate operand or conversion width |
| dst_i | input | 64 | Current destination register value |
| src_i | input | 64 | Current source register value |
| res_o | output | 64 | New destination register value |
| illegal_o | output | 1 | Unsupported encoding; res_o equals dst_i |

## Verification
The hardest corners to reach are the signed-division overflow and the zero-divisor paths in the 32-bit class. In those cases the upper half of the destination must be discarded before the signed operands are formed. Random register values almost never produce 0x80000000 against -1, or a divisor whose low word alone is zero. The stimulus therefore draws operands from a pool weighted towards zero, all-ones and the two most negative values, and it pairs them with offsets 0 and 1 and both operand sources. Directed vectors add the truncating-modulo case and each illegal encoding. A behavioural reference model then compares every vector.

// File: rtl/pkt_alu_pkg.sv
package pkt_alu_pkg;

   typedef enum logic [3:0] {
      OP_ADD  = 4'h0,
      OP_SUB  = 4'h1,
      OP_MUL  = 4'h2,
      OP_DIV  = 4'h3,
      OP_OR   = 4'h4,
      OP_AND  = 4'h5,
      OP_LSH  = 4'h6,
      OP_RSH  = 4'h7,
      OP_NEG  = 4'h8,
      OP_MOD  = 4'h9,
      OP_XOR  = 4'ha,
      OP_MOV  = 4'hb,
      OP_ARSH = 4'hc,
      OP_END  = 4'hd,
      OP_RSVE = 4'he,
      OP_RSVF = 4'hf
   } alu_code_e;

   localparam logic [2:0] CLS_NARROW = 3'd4;
   localparam logic [2:0] CLS_WIDE   = 3'd7;

   typedef enum logic [1:0] {
      SW_16  = 2'd0,
      SW_32  = 2'd1,
      SW_64  = 2'd2,
      SW_BAD = 2'd3
   } swap_w_e;

   typedef enum logic [1:0] {
      SX_NONE = 2'd0,
      SX_B    = 2'd1,
      SX_H    = 2'd2,
      SX_W    = 2'd3
   } sx_sel_e;

   typedef struct packed {
      logic      wide;
      logic      use_reg;
      alu_code_e code;
      logic      sgn;
      sx_sel_e   sx;
      swap_w_e   sw;
      logic      illegal;
   } alu_dec_t;

endpackage

// File: rtl/pkt_alu_legal.sv
module pkt_alu_legal
   import pkt_alu_pkg::*;
(
   input  logic [7:0]  op_i,
   input  logic [15:0] off_i,
   input  logic [31:0] imm_i,
   output alu_dec_t    dec_o
);

   logic cls_ok;
   logic enc_ok;
   alu_dec_t d;

   always_comb begin
      d         = '0;
      d.code    = alu_code_e'(op_i[7:4]);
      d.use_reg = op_i[3];
      d.wide    = (op_i[2:0] == CLS_WIDE);
      d.sx      = SX_NONE;
      d.sw      = SW_BAD;
      cls_ok    = (op_i[2:0] == CLS_NARROW) || d.wide;
      enc_ok    = 1'b1;
      unique case (d.code)
         OP_DIV, OP_MOD: begin
            enc_ok = (off_i == 16'd0) || (off_i == 16'd1);
            d.sgn  = (off_i == 16'd1);
         end
         OP_MOV: begin
            case (off_i)
               16'd0:   d.sx = SX_NONE;
               16'd8:   d.sx = SX_B;
               16'd16:  d.sx = SX_H;
               16'd32:  begin d.sx = SX_W; enc_ok = d.wide; end
               default: enc_ok = 1'b0;
            endcase
         end
         OP_END: begin
            case (imm_i)
               32'd16:  d.sw = SW_16;
               32'd32:  d.sw = SW_32;
               32'd64:  d.sw = SW_64;
               default: d.sw = SW_BAD;
            endcase
            enc_ok = (off_i == 16'd0) && (d.sw != SW_BAD) && !(d.wide && d.use_reg);
         end
         OP_RSVE, OP_RSVF: enc_ok = 1'b0;
         default: enc_ok = (off_i == 16'd0);
      endcase
      d.illegal = !(cls_ok && enc_ok);
   end

   assign dec_o = d;

   // R10: reserved codes can never be reported as legal
   always_comb begin
      if (!$isunknown(op_i) && !$isunknown(off_i) && !$isunknown(imm_i)) begin
         a_r10_rsv_flagged: assert (!(op_i[7:5] == 3'b111 && dec_o.code != OP_ARSH && dec_o.code != OP_END) || dec_o.illegal)
            else $error("reserved code reported legal");
      end
   end

endmodule

// File: rtl/pkt_alu_divmod.sv
module pkt_alu_divmod #(
   parameter int W = 64
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         sgn_i,
   output logic [W-1:0] quo_o,
   output logic [W-1:0] rem_o
);

   logic         neg_a, neg_b, b_zero;
   logic [W-1:0] mag_a, mag_b, div_b, uq, ur;

   always_comb begin
      neg_a  = sgn_i && a_i[W-1];
      neg_b  = sgn_i && b_i[W-1];
      mag_a  = neg_a ? (~a_i + 1'b1) : a_i;
      mag_b  = neg_b ? (~b_i + 1'b1) : b_i;
      b_zero = (b_i == '0);
      div_b  = b_zero ? W'(1) : mag_b;
      uq     = mag_a / div_b;
      ur     = mag_a % div_b;
      if (b_zero) begin
         quo_o = '0;
         rem_o = a_i;
      end else begin
         quo_o = (neg_a ^ neg_b) ? (~uq + 1'b1) : uq;
         rem_o = neg_a ? (~ur + 1'b1) : ur;
      end
   end

   // R4: unsigned quotient and remainder rebuild the dividend
   always_comb begin
      if (!$isunknown(a_i) && !$isunknown(b_i) && !$isunknown(sgn_i)) begin
         if (!sgn_i && b_i != '0) begin
            a_r4_udiv_identity: assert (W'(quo_o * b_i + rem_o) == a_i && rem_o < b_i)
               else $error("unsigned divide identity broken");
         end
      end
   end

endmodule

// File: rtl/pkt_alu_swap.sv
module pkt_alu_swap
   import pkt_alu_pkg::*;
#(
   parameter int W = 64
) (
   input  logic [W-1:0] val_i,
   input  swap_w_e      sel_i,
   input  logic         rev_i,
   output logic [W-1:0] val_o
);

   localparam int NW = $clog2(W / 8);

   logic [W-1:0] cand [NW];

   for (genvar k = 0; k < NW; k++) begin : g_width
      localparam int NB = 2 << k;
      logic [NB*8-1:0] fwd, bwd;
      assign fwd = val_i[NB*8-1:0];
      for (genvar j = 0; j < NB; j++) begin : g_byte
         assign bwd[8*j +: 8] = val_i[8*(NB-1-j) +: 8];
      end
      assign cand[k] = W'(rev_i ? bwd : fwd);
   end

   always_comb begin
      val_o = '0;
      for (int k = 0; k < NW; k++) begin
         if (int'(sel_i) == k) val_o = cand[k];
      end
   end

   // R9: a full-width swap only moves bits, never creates or drops them
   always_comb begin
      if (!$isunknown(val_i) && !$isunknown(sel_i) && !$isunknown(rev_i)) begin
         if (int'(sel_i) == NW - 1) begin
            a_r9_bits_kept: assert ($countones(val_o) == $countones(val_i))
               else $error("full-width swap changed bit count");
         end
      end
   end

endmodule

// File: rtl/pkt_alu_exec.sv
module pkt_alu_exec
   import pkt_alu_pkg::*;
#(
   parameter int XLEN    = 64,
   parameter bit HOST_LE = 1'b1
) (
   input  logic [7:0]      op_i,
   input  logic [15:0]     off_i,
   input  logic [31:0]     imm_i,
   input  logic [XLEN-1:0] dst_i,
   input  logic [XLEN-1:0] src_i,
   output logic [XLEN-1:0] res_o,
   output logic            illegal_o
);

   localparam int HALF = XLEN / 2;
   localparam int SHW  = $clog2(XLEN);

   if (XLEN != 64) begin : g_bad_xlen
      $error("pkt_alu_exec needs XLEN of 64");
   end

   alu_dec_t        dec;
   logic [XLEN-1:0] imm_x, b_raw, a, b, a_h, b_h;
   logic [XLEN-1:0] dv_a, dv_b, quo, rem, swapped, mv, calc;
   logic [SHW-1:0]  shamt;
   logic            rev;

   pkt_alu_legal u_legal (
      .op_i  (op_i),
      .off_i (off_i),
      .imm_i (imm_i),
      .dec_o (dec)
   );

   always_comb begin
      imm_x = {{(XLEN-32){imm_i[31]}}, imm_i};
      b_raw = dec.use_reg ? src_i : imm_x;
      a     = dec.wide ? dst_i : {{HALF{1'b0}}, dst_i[HALF-1:0]};
      b     = dec.wide ? b_raw : {{HALF{1'b0}}, b_raw[HALF-1:0]};
      a_h   = {{HALF{dst_i[HALF-1]}}, dst_i[HALF-1:0]};
      b_h   = {{HALF{b_raw[HALF-1]}}, b_raw[HALF-1:0]};
      dv_a  = (dec.sgn && !dec.wide) ? a_h : a;
      dv_b  = (dec.sgn && !dec.wide) ? b_h : b;
      shamt = dec.wide ? b[SHW-1:0] : {1'b0, b[SHW-2:0]};
      rev   = dec.wide || (dec.use_reg == HOST_LE);
   end

   pkt_alu_divmod #(.W(XLEN)) u_divmod (
      .a_i   (dv_a),
      .b_i   (dv_b),
      .sgn_i (dec.sgn),
      .quo_o (quo),
      .rem_o (rem)
   );

   pkt_alu_swap #(.W(XLEN)) u_swap (
      .val_i (dst_i),
      .sel_i (dec.sw),
      .rev_i (rev),
      .val_o (swapped)
   );

   always_comb begin
      unique case (dec.sx)
         SX_B:    mv = {{(XLEN-8){b_raw[7]}}, b_raw[7:0]};
         SX_H:    mv = {{(XLEN-16){b_raw[15]}}, b_raw[15:0]};
         SX_W:    mv = {{(XLEN-32){b_raw[31]}}, b_raw[31:0]};
         default: mv = b;
      endcase
   end

   always_comb begin
      unique case (dec.code)
         OP_ADD:  calc = a + b;
         OP_SUB:  calc = a - b;
         OP_MUL:  calc = a * b;
         OP_DIV:  calc = quo;
         OP_OR:   calc = a | b;
         OP_AND:  calc = a & b;
         OP_LSH:  calc = a << shamt;
         OP_RSH:  calc = a >> shamt;
         OP_NEG:  calc = ~a + 1'b1;
         OP_MOD:  calc = rem;
         OP_XOR:  calc = a ^ b;
         OP_MOV:  calc = mv;
         OP_ARSH: calc = dec.wide ? XLEN'($signed(a) >>> shamt) : XLEN'($signed(a_h) >>> shamt);
         OP_END:  calc = swapped;
         default: calc = dst_i;
      endcase
      if (!dec.wide && dec.code != OP_END) calc = {{HALF{1'b0}}, calc[HALF-1:0]};
   end

   assign illegal_o = dec.illegal;
   assign res_o     = dec.illegal ? dst_i : calc;

   always_comb begin
      if (!$isunknown({op_i, off_i, imm_i, dst_i, src_i})) begin
         // R2: narrow-class results carry nothing above bit 31
         a_r2_upper_clear: assert (illegal_o || op_i[2:0] != CLS_NARROW || op_i[7:4] == 4'hd || res_o[XLEN-1:HALF] == '0)
            else $error("upper half not cleared");
         // R5: divide by zero gives zero
         a_r5_div_zero: assert (illegal_o || op_i[7:4] != 4'h3 || dv_b != '0 || res_o == '0)
            else $error("divide by zero not zero");
         // R5: wide modulo by zero keeps destination
         a_r5_mod_keep: assert (illegal_o || op_i[7:4] != 4'h9 || op_i[2:0] != CLS_WIDE || dv_b != '0 || res_o == dst_i)
            else $error("modulo by zero changed destination");
         // R3: a zero shift amount leaves the operand as it is
         a_r3_zero_shift: assert (illegal_o || !(op_i[7:4] == 4'h6 || op_i[7:4] == 4'h7) || shamt != '0 || res_o == a)
            else $error("zero shift altered value");
         // R10: non-arithmetic classes are always flagged
         a_r10_bad_class: assert (op_i[2:0] == CLS_NARROW || op_i[2:0] == CLS_WIDE || (illegal_o && res_o == dst_i))
            else $error("foreign class not flagged");
      end
   end

endmodule

// File: tb/pkt_alu_exec_tb.sv
module pkt_alu_exec_tb;

   logic        clk = 1'b0;
   logic [7:0]  op;
   logic [15:0] off;
   logic [31:0] imm;
   logic [63:0] dst, src;
   logic [63:0] res;
   logic        ill;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 0;

   always #2 clk = ~clk;

   pkt_alu_exec u_dut (
      .op_i      (op),
      .off_i     (off),
      .imm_i     (imm),
      .dst_i     (dst),
      .src_i     (src),
      .res_o     (res),
      .illegal_o (ill)
   );

   localparam logic [63:0] MIN64 = 64'h8000_0000_0000_0000;

   function automatic logic [64:0] ref_exec(input logic [7:0] o, input logic [15:0] f,
                                            input logic [31:0] im, input logic [63:0] d,
                                            input logic [63:0] s);
      logic [2:0]  cls;
      logic [3:0]  code;
      logic        x, w64, bad, swp;
      logic [63:0] bv, a, b, r;
      longint      sa, sb;
      int          sh, nb;
      cls  = o[2:0];
      code = o[7:4];
      x    = o[3];
      w64  = (cls == 3'd7);
      bad  = !(cls == 3'd4 || w64);
      bv   = x ? s : {{32{im[31]}}, im};
      a    = w64 ? d : {32'h0, d[31:0]};
      b    = w64 ? bv : {32'h0, bv[31:0]};
      sh   = w64 ? int'(b[5:0]) : int'(b[4:0]);
      r    = d;
      if (!(code == 4'h3 || code == 4'h9 || code == 4'hb) && f != 16'd0) bad = 1'b1;
      case (code)
         4'h0: r = a + b;
         4'h1: r = a - b;
         4'h2: r = a * b;
         4'h4: r = a | b;
         4'h5: r = a & b;
         4'h6: r = a << sh;
         4'h7: r = a >> sh;
         4'h8: r = -a;
         4'ha: r = a ^ b;
         4'hc: begin
            sa = w64 ? longint'(a) : longint'({{32{a[31]}}, a[31:0]});
            r  = 64'(sa >>> sh);
         end
         4'hb: begin
            case (f)
               16'd0:   r = b;
               16'd8:   r = {{56{bv[7]}}, bv[7:0]};
               16'd16:  r = {{48{bv[15]}}, bv[15:0]};
               16'd32:  if (w64) r = {{32{bv[31]}}, bv[31:0]}; else bad = 1'b1;
               default: bad = 1'b1;
            endcase
         end
         4'h3, 4'h9: begin
            if (f > 16'd1) bad = 1'b1;
            else if (f == 16'd0) begin
               if (b == 64'd0) r = (code == 4'h3) ? 64'd0 : a;
               else            r = (code == 4'h3) ? a / b : a % b;
            end else begin
               sa = w64 ? longint'(a) : longint'({{32{a[31]}}, a[31:0]});
               sb = w64 ? longint'(b) : longint'({{32{b[31]}}, b[31:0]});
               if (sb == 0) r = (code == 4'h3) ? 64'd0 : a;
               else if (64'(sa) == MIN64 && sb == -1) r = (code == 4'h3) ? MIN64 : 64'd0;
               else r = (code == 4'h3) ? 64'(sa / sb) : 64'(sa % sb);
            end
         end
         4'hd: begin
            nb  = (im == 32'd16) ? 2 : (im == 32'd32) ? 4 : (im == 32'd64) ? 8 : 0;
            swp = w64 || x;
            if (nb == 0 || (w64 && x)) bad = 1'b1;
            else begin
               r = 64'd0;
               for (int i = 0; i < nb; i++)
                  r[8*i +: 8] = swp ? d[8*(nb-1-i) +: 8] : d[8*i +: 8];
            end
         end
         default: bad = 1'b1;
      endcase
      if (!w64 && code != 4'hd) r[63:32] = 32'h0;
      if (bad) r = d;
      return {bad, r};
   endfunction

   function automatic string req_of(input logic [7:0] o);
      if (!(o[2:0] == 3'd4 || o[2:0] == 3'd7)) return "R10";
      case (o[7:4])
         4'h3, 4'h9:       return "R4/R5/R6";
         4'h6, 4'h7, 4'hc: return "R3";
         4'hb:             return "R7";
         4'hd:             return (o[2:0] == 3'd7) ? "R9" : "R8";
         4'he, 4'hf:       return "R10";
         default:          return "R2";
      endcase
   endfunction

   task automatic run(input logic [7:0] o, input logic [15:0] f, input logic [31:0] im,
                      input logic [63:0] d, input logic [63:0] s, input string tag);
      logic [64:0] exp;
      @(negedge clk);
      op = o; off = f; imm = im; dst = d; src = s;
      exp = ref_exec(o, f, im, d, s);
      @(posedge clk);
      #1;
      n_cmp++;
      if ({ill, res} !== exp) begin
         n_bad++;
         $display("FAIL %s op=%02h off=%0d imm=%08h dst=%016h src=%016h actual=%0b/%016h expected=%0b/%016h",
                  tag, o, f, im, d, s, ill, res, exp[64], exp[63:0]);
      end
   endtask

   function automatic logic [63:0] pick_val();
      case ($urandom % 8)
         0: return 64'd0;
         1: return MIN64;
         2: return '1;
         3: return 64'h0000_0000_8000_0000;
         4: return 64'hFFFF_FFFF_FFFF_FFFF - 64'($urandom % 20);
         5: return 64'($urandom % 16);
         default: return {$urandom, $urandom};
      endcase
   endfunction

   initial begin
      op = 8'h07; off = '0; imm = '0; dst = '0; src = '0;
      repeat (2) @(posedge clk);
      // R1: immediate sign-extended vs register source
      run(8'h07, 0, 32'hFFFF_FFFF, 64'd5, 64'd9, "R1");
      run(8'h0f, 0, 32'hFFFF_FFFF, 64'd5, 64'd9, "R1");
      // R2: narrow wrap and upper clear
      run(8'h0c, 0, 0, '1, 64'd1, "R2");
      run(8'h8c, 0, 0, 64'h1234_5678_0000_0001, 0, "R2");
      // R3: masking and sign fill
      run(8'h6f, 0, 0, 64'd3, 64'd65, "R3");
      run(8'hcc, 0, 0, 64'hAAAA_AAAA_8000_0000, 64'd36, "R3");
      run(8'hcf, 0, 0, MIN64, 64'd63, "R3");
      // R4: unsigned divide by sign-extended immediate
      run(8'h37, 0, 32'hFFFF_FFFF, 64'd10, 0, "R4");
      run(8'h97, 0, 32'hFFFF_FFFE, 64'd10, 0, "R4");
      // R5: zero divisor
      run(8'h3f, 0, 0, 64'd77, 0, "R5");
      run(8'h9f, 0, 0, 64'hDEAD_BEEF_0000_0011, 0, "R5");
      run(8'h9c, 0, 0, 64'hDEAD_BEEF_0000_0011, 64'hFFFF_0000_0000_0000, "R5");
      // R6: signed truncating, overflow
      run(8'h9f, 1, 0, -64'sd13, 64'd3, "R6");
      run(8'h3f, 1, 0, MIN64, '1, "R6");
      run(8'h9f, 1, 0, MIN64, '1, "R6");
      run(8'h3c, 1, 0, 64'h0000_0000_8000_0000, '1, "R6");
      run(8'h9c, 1, 0, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, "R6");
      // R7: sign-extending move
      run(8'hbf, 8, 0, 0, 64'h80, "R7");
      run(8'hbc, 16, 0, 0, 64'h8001, "R7");
      run(8'hb7, 32, 32'h8000_0000, 0, 0, "R7");
      run(8'hbc, 32, 0, 0, 64'h8001, "R7");
      // R8: narrow-class conversions
      run(8'hdc, 0, 16, 64'h1122_3344_5566_1234, 0, "R8");
      run(8'hd4, 0, 32, 64'h1122_3344_5566_7788, 0, "R8");
      run(8'hdc, 0, 64, 64'h0102_0304_0506_0708, 0, "R8");
      // R9: unconditional swap
      run(8'hd7, 0, 64, 64'h0102_0304_0506_0708, 0, "R9");
      run(8'hd7, 0, 16, 64'h0102_0304_0506_0708, 0, "R9");
      // R10: illegal encodings
      run(8'hd7, 0, 8, 64'h55, 0, "R10");
      run(8'hdf, 0, 64, 64'h55, 0, "R10");
      run(8'h0f, 5, 0, 64'h55, 1, "R10");
      run(8'h05, 0, 0, 64'h55, 1, "R10");
      run(8'he7, 0, 0, 64'h55, 1, "R10");
      run(8'h3f, 2, 0, 64'h55, 1, "R10");
      for (int i = 0; i < 4000; i++) begin
         logic [7:0]  o;
         logic [15:0] f;
         logic [31:0] im;
         logic [2:0]  cls;
         cls = (($urandom % 8) != 0) ? ((($urandom % 2) != 0) ? 3'd4 : 3'd7) : 3'($urandom);
         o   = {4'($urandom), 1'($urandom), cls};
         case ($urandom % 8)
            0, 1, 2: f = 16'd0;
            3:       f = 16'd1;
            4:       f = 16'd8;
            5:       f = 16'd16;
            6:       f = 16'd32;
            default: f = 16'($urandom);
         endcase
         if (o[7:4] == 4'hd) begin
            case ($urandom % 5)
               0: im = 32'd16; 1: im = 32'd32; 2: im = 32'd64; 3: im = 32'd8;
               default: im = $urandom;
            endcase
            if (($urandom % 4) != 0) f = 16'd0;
         end else begin
            im = 32'(pick_val());
         end
         run(o, f, im, pick_val(), pick_val(), req_of(o));
      end
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      for (int c = 0; c < 100000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule